// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block is the control engine of an eight-input, 12-bit successive-approximation converter. Software writes a control word in one cycle. The word carries a channel mask, a clock divide value, a scan enable, a power bit, a start code and a trigger polarity. From that word the block produces a converter clock enable and issues conversion requests to an abstract converter. Each request is a one-cycle pulse with a 3-bit channel number. The converter answers with a done strobe and a 12-bit sample, and the block forwards the sample, tagged with its channel, for one cycle.

There are three ways to start a conversion:
- **Convert now:** a single conversion starts when the control word is written.
- **Triggered:** a single conversion starts on a chosen edge of one of six external trigger lines.
- **Scan:** the block converts every channel in the mask continuously, in rotating order, and never waits for software.

Writing the control word always abandons any conversion in flight. If the new word calls for an immediate start, the next conversion is issued at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `req_start`, `busy`, `res_valid` and `cclk_en` are all 0.
- R2: While the power bit is 1, `cclk_en` is high for one cycle in every `div`+1 cycles. After a write, the first pulse comes in the (`div`+1)th cycle. While the power bit is 0, `cclk_en` stays 0.
- R3: Start code 3'b001, scan off, power on and exactly one mask bit set (bit n selects channel n) gives one `req_start` pulse. The pulse comes in the cycle after the write, and `req_chan` equals n. No further request follows the answer.
- R4: With scan off, a mask with zero bits set or more than one bit set issues no request, for any start code.
- R5: With scan on, the first request goes to the lowest set mask bit. Each accepted done strobe issues the next request in the following cycle, to the next set bit above the current channel, wrapping from 7 back to 0.
- R6: With scan on and an all-zero mask, no request is issued.
- R7: Start codes 3'b010 to 3'b111 select trigger line `trig_in[code-2]`. Polarity bit 1 triggers on a rising edge and 0 on a falling edge. A qualifying edge produces one request in the third cycle after the line changes. Edges of the other polarity, or on an unselected line, produce none.
- R8: When the power bit is 0, no request is issued in any mode.
- R9: A write during a conversion abandons it, and a late done strobe for it yields no result. If the new word calls for convert-now or scan, the new request comes in the cycle after the write.
- R10: A done strobe accepted while busy gives `res_valid` for one cycle in the next cycle, carrying the requested channel and `rsp_data`. A done strobe while idle is ignored.
- R11: Start code 3'b000 issues no request. Trigger edges are also ignored while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_mask | input | 8 | Channel mask, bit n = channel n |
| ctl_div | input | DIV_W | Converter clock divide value minus one |
| ctl_scan | input | 1 | Continuous rotating scan enable |
| ctl_pwr | input | 1 | Power bit, 1 = operational |
| ctl_start | input | 3 | Start code |
| ctl_rise | input | 1 | Trigger polarity, 1 = rising |
| trig_in | input | 6 | Asynchronous external trigger lines |
| rsp_done | input | 1 | Converter done strobe |
| rsp_data | input | DATA_W | Converter sample |
| cclk_en | output | 1 | Converter clock enable pulse |
| req_start | output | 1 | Conversion request pulse |
| req_chan | output | 3 | Channel of the current request |
| busy | output | 1 | A conversion is outstanding |
| res_valid | output | 1 | Result pulse |
| res_chan | output | 3 | Channel of the result |
| res_data | output | DATA_W | Sample of the result |

## Verification
Single-start mode is tried with two masks:
- a one-hot mask, which must be honoured;
- a two-bit mask, which must be refused. This pair separates a proper one-hot test from a test that only checks for a non-zero mask.

Scan is tried with three masks:
- a sparse three-bit mask (channels 2, 5 and 7), which exposes wrong successor or wrap-around logic;
- an empty mask;
- a full mask with power off.

Triggers are tried with four edge cases:
- an edge on the wrong line;
- an edge of the wrong polarity;
- an edge while busy;
- a correct edge, timed to the cycle.

Together these separate a faulty line select, polarity handling or synchronizer depth. Write-during-conversion cases check that the abandoned answer is dropped and that the replacement request starts at once.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_mask,
  input  logic [DIV_W-1:0]  ctl_div,
  input  logic              ctl_scan,
  input  logic              ctl_pwr,
  input  logic [2:0]        ctl_start,
  input  logic              ctl_rise,
  input  logic [5:0]        trig_in,
  input  logic              rsp_done,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              cclk_en,
  output logic              req_start,
  output logic [2:0]        req_chan,
  output logic              busy,
  output logic              res_valid,
  output logic [2:0]        res_chan,
  output logic [DATA_W-1:0] res_data
);
  localparam logic [2:0] CODE_NOW = 3'd1;
  localparam logic [2:0] CODE_TRIG0 = 3'd2;

  logic [7:0]        mask_q;
  logic [DIV_W-1:0]  div_q, cnt_q;
  logic              scan_q, pwr_q, rise_q;
  logic [2:0]        code_q, chan_q;
  logic [5:0]        s1_q, s2_q, prev_q;
  logic              busy_q, req_q;
  logic              rv_q;
  logic [2:0]        rc_q;
  logic [DATA_W-1:0] rd_q;

  function automatic logic single(input logic [7:0] m);
    return $countones(m) == 1;
  endfunction

  function automatic logic [2:0] lowest(input logic [7:0] m);
    logic [2:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--)
      if (m[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [2:0] after(input logic [7:0] m, input logic [2:0] base);
    logic [2:0] r;
    logic       hit;
    r   = base;
    hit = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      if (!hit && m[(int'(base) + i) & 7]) begin
        r   = 3'((int'(base) + i) & 7);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [2:0] trig_idx;
  logic       trig_mode, edge_seen, trig_hit, wr_go;

  assign trig_idx  = code_q - CODE_TRIG0;
  assign trig_mode = code_q >= CODE_TRIG0;
  assign edge_seen = rise_q ? (s2_q[trig_idx] & ~prev_q[trig_idx])
                            : (~s2_q[trig_idx] & prev_q[trig_idx]);
  assign trig_hit  = pwr_q && !scan_q && trig_mode && single(mask_q) && !busy_q && edge_seen;
  assign wr_go     = ctl_pwr && (ctl_scan ? (ctl_mask != '0)
                                          : (ctl_start == CODE_NOW && single(ctl_mask)));

  assign cclk_en   = pwr_q && (cnt_q == div_q);
  assign req_start = req_q;
  assign req_chan  = chan_q;
  assign busy      = busy_q;
  assign res_valid = rv_q;
  assign res_chan  = rc_q;
  assign res_data  = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= trig_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (ctl_wr || !pwr_q || cnt_q == div_q) cnt_q <= '0;
      else                                    cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      div_q  <= '0;
      scan_q <= 1'b0;
      pwr_q  <= 1'b0;
      code_q <= '0;
      rise_q <= 1'b0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      chan_q <= '0;
      rv_q   <= 1'b0;
      rc_q   <= '0;
      rd_q   <= '0;
    end else begin
      req_q <= 1'b0;
      rv_q  <= 1'b0;
      if (ctl_wr) begin
        mask_q <= ctl_mask;
        div_q  <= ctl_div;
        scan_q <= ctl_scan;
        pwr_q  <= ctl_pwr;
        code_q <= ctl_start;
        rise_q <= ctl_rise;
        busy_q <= wr_go;
        req_q  <= wr_go;
        if (wr_go) chan_q <= lowest(ctl_mask);
      end else if (busy_q && rsp_done) begin
        rv_q <= 1'b1;
        rc_q <= chan_q;
        rd_q <= rsp_data;
        if (scan_q && pwr_q && mask_q != '0) begin
          busy_q <= 1'b1;
          req_q  <= 1'b1;
          chan_q <= after(mask_q, chan_q);
        end else begin
          busy_q <= 1'b0;
        end
      end else if (trig_hit) begin
        busy_q <= 1'b1;
        req_q  <= 1'b1;
        chan_q <= lowest(mask_q);
      end
    end
  end

  a_r1_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> busy_q);
  a_r8_no_activity_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |-> (!req_q && !busy_q && !cclk_en));
  a_r4_single_needs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !scan_q) |-> ($countones(mask_q) == 1));
  a_r5_req_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> mask_q[chan_q]);
  a_r10_result_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> $past(busy_q));
  a_r11_stop_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !scan_q) |-> (code_q != 3'd0));
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_mask = '0;
  logic [7:0]  ctl_div = '0;
  logic        ctl_scan = 1'b0, ctl_pwr = 1'b0, ctl_rise = 1'b0;
  logic [2:0]  ctl_start = '0;
  logic [5:0]  trig_in = '0;
  logic        rsp_done = 1'b0;
  logic [11:0] rsp_data = '0;
  logic        cclk_en, req_start, busy, res_valid;
  logic [2:0]  req_chan, res_chan;
  logic [11:0] res_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk, .rst_n, .ctl_wr, .ctl_mask, .ctl_div, .ctl_scan, .ctl_pwr,
    .ctl_start, .ctl_rise, .trig_in, .rsp_done, .rsp_data,
    .cclk_en, .req_start, .req_chan, .busy, .res_valid, .res_chan, .res_data
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] m, input logic [7:0] d, input logic sc,
                    input logic p, input logic [2:0] c, input logic r);
    ctl_wr = 1'b1; ctl_mask = m; ctl_div = d; ctl_scan = sc;
    ctl_pwr = p; ctl_start = c; ctl_rise = r;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic done(input logic [11:0] d);
    rsp_done = 1'b1; rsp_data = d;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  task automatic count_reqs(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_start) cnt++;
    end
  endtask

  task automatic t_reset;
    chk(req_start, 0, "R1 req_start");
    chk(busy, 0, "R1 busy");
    chk(res_valid, 0, "R1 res_valid");
    chk(cclk_en, 0, "R1 cclk_en");
  endtask

  task automatic t_clkdiv;
    int pat;
    wr(8'h00, 8'd3, 0, 1, 3'd0, 0);
    pat = 0;
    for (int i = 0; i < 8; i++) begin
      pat = (pat << 1) | int'(cclk_en);
      @(negedge clk);
    end
    chk(pat, 8'b0001_0001, "R2 div3 pattern");
    wr(8'h00, 8'd0, 0, 1, 3'd0, 0);
    pat = 0;
    for (int i = 0; i < 4; i++) begin
      pat = (pat << 1) | int'(cclk_en);
      @(negedge clk);
    end
    chk(pat, 4'b1111, "R2 div0 pattern");
    wr(8'h00, 8'd0, 0, 0, 3'd0, 0);
    chk(cclk_en, 0, "R2 unpowered cclk_en");
  endtask

  task automatic t_sw_start;
    int n;
    wr(8'h10, 8'd0, 0, 1, 3'd1, 0);
    chk(req_start, 1, "R3 req pulse");
    chk(req_chan, 4, "R3 req_chan");
    @(negedge clk);
    chk(req_start, 0, "R3 single pulse");
    done(12'hABC);
    chk(res_valid, 1, "R10 res_valid");
    chk(res_chan, 4, "R10 res_chan");
    chk(res_data, 12'hABC, "R10 res_data");
    count_reqs(5, n);
    chk(n, 0, "R3 no repeat");
    done(12'h123);
    chk(res_valid, 0, "R10 idle done ignored");
  endtask

  task automatic t_sw_multi;
    int n;
    wr(8'h30, 8'd0, 0, 1, 3'd1, 0);
    chk(req_start, 0, "R4 two bits no req");
    count_reqs(3, n);
    chk(n + int'(busy), 0, "R4 stays idle");
    wr(8'h00, 8'd0, 0, 1, 3'd1, 0);
    chk(req_start, 0, "R4 empty mask no req");
  endtask

  task automatic t_scan;
    wr(8'hA4, 8'd0, 1, 1, 3'd0, 0);
    chk(req_chan, 2, "R5 first chan");
    chk(req_start, 1, "R5 first req");
    @(negedge clk);
    done(12'h001);
    chk(req_start, 1, "R5 second req");
    chk(req_chan, 5, "R5 second chan");
    done(12'h002);
    chk(req_chan, 7, "R5 third chan");
    done(12'h003);
    chk(req_chan, 2, "R5 wrap chan");
    chk(res_chan, 7, "R10 scan res_chan");
    wr(8'h00, 8'd0, 0, 1, 3'd0, 0);
  endtask

  task automatic t_scan_zero;
    int n;
    wr(8'h00, 8'd0, 1, 1, 3'd0, 0);
    count_reqs(4, n);
    chk(n, 0, "R6 empty scan");
  endtask

  task automatic t_pwr_off;
    int n;
    wr(8'hFF, 8'd0, 1, 0, 3'd1, 0);
    count_reqs(4, n);
    chk(n + int'(cclk_en), 0, "R8 unpowered scan");
  endtask

  task automatic t_restart;
    int n;
    wr(8'h24, 8'd0, 1, 1, 3'd0, 0);
    chk(req_chan, 2, "R9 scan start");
    @(negedge clk);
    wr(8'h08, 8'd0, 0, 1, 3'd1, 0);
    chk(req_start, 1, "R9 restart req");
    chk(req_chan, 3, "R9 restart chan");
    done(12'h5A5);
    chk(res_chan, 3, "R9 restarted result chan");
    wr(8'h08, 8'd0, 0, 1, 3'd1, 0);
    @(negedge clk);
    wr(8'h08, 8'd0, 0, 1, 3'd0, 0);
    chk(busy, 0, "R9 stop aborts");
    done(12'h777);
    chk(res_valid, 0, "R9 stale done dropped");
    count_reqs(3, n);
    chk(n, 0, "R11 stop code no req");
  endtask

  task automatic t_trig_rise;
    int n;
    wr(8'h02, 8'd0, 0, 1, 3'd4, 1);
    trig_in[0] = 1'b1;
    count_reqs(5, n);
    chk(n, 0, "R7 unselected line");
    trig_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(req_start, 0, "R7 not early");
    @(negedge clk);
    chk(req_start, 1, "R7 rising req");
    chk(req_chan, 1, "R7 rising chan");
    trig_in[2] = 1'b0;
    count_reqs(4, n);
    trig_in[2] = 1'b1;
    count_reqs(4, n);
    chk(n, 0, "R11 edge while busy ignored");
    done(12'h0F0);
    chk(res_chan, 1, "R7 trig result chan");
    trig_in[2] = 1'b0;
    count_reqs(5, n);
    chk(n, 0, "R7 wrong polarity");
    trig_in[0] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_trig_fall;
    int n;
    wr(8'h80, 8'd0, 0, 1, 3'd7, 0);
    trig_in[5] = 1'b1;
    count_reqs(5, n);
    chk(n, 0, "R7 rising ignored for falling");
    trig_in[5] = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(req_start, 1, "R7 falling req");
    chk(req_chan, 7, "R7 falling chan");
    done(12'hFFF);
    chk(res_data, 12'hFFF, "R10 trig data");
    count_reqs(5, n);
    chk(n, 0, "R7 one per edge");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clkdiv();
    t_sw_start();
    t_sw_multi();
    t_scan();
    t_scan_zero();
    t_pwr_off();
    t_restart();
    t_trig_rise();
    t_trig_fall();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule